// File: doc/BRIEF.md
# Two-Key Decimal Up/Down Counter with Scanned Display

This block keeps a two-digit decimal count that an operator changes with two push buttons. One button steps the count up and the other steps it down. Each button acts once per complete press-and-release, and the step is taken when the key is let go. The count is kept as two BCD digits, tens and units, and wraps within 00..99 in both directions.

Each raw key passes through a two-flop synchronizer and a debouncer, and then through a release detector that emits a one-cycle step pulse. The two digits drive a pair of common-cathode seven-segment displays that are time-multiplexed. An active-low enable selects one digit at a time, and the shared active-high segment bus carries that digit's pattern. The debounce window, the scan period and the key polarity are parameters.

Top module: `dual_key_decade_display`

## Requirements
- R1: A debounced press-then-release of `key_up` increases the count by one, and the units digit carries into the tens digit when it passes 9.
- R2: A debounced press-then-release of `key_dn` decreases the count by one, and the units digit borrows from the tens digit when it passes 0.
- R3: An increment from 99 gives 00.
- R4: A decrement from 00 gives 99.
- R5: While a key is held down the count does not change. The step happens only after the key is released.
- R6: A key level that lasts fewer than `DEBOUNCE_CYCLES` clock cycles is ignored and does not change the count.
- R7: If both keys release in the same clock cycle, the count is unchanged.
- R8: Asserting `arst` (active high, asynchronous) sets the count to 00.
- R9: `dig_n` is active low, with exactly one bit low at any time. `dig_n[0]` enables the units digit and `dig_n[1]` enables the tens digit. The enabled digit changes every `SCAN_CYCLES` clocks.
- R10: `seg` is active high with bit 0 = a, bit 1 = b, and so on up to bit 6 = g. The digit patterns are 0=7'h3F, 1=7'h06, 2=7'h5B, 3=7'h4F, 4=7'h66, 5=7'h6D, 6=7'h7D, 7=7'h07, 8=7'h7F, 9=7'h6F. The bus carries the pattern of whichever digit is enabled.
- R11: Each stored digit always lies in the range 0..9.
- R12: A step pulse lasts exactly one clock cycle for each release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst | input | 1 | Asynchronous reset, active high |
| key_up | input | 1 | Raw count-up key, high when pressed by default |
| key_dn | input | 1 | Raw count-down key, high when pressed by default |
| seg | output | 7 | Segment drive a..g, active high |
| dig_n | output | 2 | Digit enables, active low: [0] units, [1] tens |

## Verification
The assertions assume that the step pulses come only from the debounced key paths. They also assume that any key activity the bench cares about holds longer than the debounce window, so that each release yields one clean pulse. The stimulus drives the keys on the falling clock edge and holds every intended press and every gap for well over `DEBOUNCE_CYCLES` cycles. Glitches are made deliberately shorter than that window, and simultaneous releases are driven in the same cycle on both keys. Results are read only through the scanned segment and digit-enable outputs, and each digit is decoded while it is enabled.

// File: rtl/kdc_pkg.sv
package kdc_pkg;
   localparam int DIGIT_W = 4;
   localparam int SEG_W   = 7;

   typedef logic [DIGIT_W-1:0] bcd_t;
   typedef logic [SEG_W-1:0]   seg_t;

   // active-high pattern, bit0 = segment a ... bit6 = segment g
   function automatic seg_t bcd_to_seg(input bcd_t d);
      seg_t s;
      case (d)
         4'd0:    s = 7'h3F;
         4'd1:    s = 7'h06;
         4'd2:    s = 7'h5B;
         4'd3:    s = 7'h4F;
         4'd4:    s = 7'h66;
         4'd5:    s = 7'h6D;
         4'd6:    s = 7'h7D;
         4'd7:    s = 7'h07;
         4'd8:    s = 7'h7F;
         4'd9:    s = 7'h6F;
         default: s = 7'h00;
      endcase
      return s;
   endfunction
endpackage

// File: rtl/kdc_key_filter.sv
module kdc_key_filter #(
   parameter int DEBOUNCE_CYCLES = 500000,
   parameter bit PRESS_LEVEL     = 1'b1
) (
   input  logic clk,
   input  logic arst,
   input  logic key_raw,
   output logic release_pulse
);
   localparam int CNT_W = $clog2(DEBOUNCE_CYCLES + 1);

   logic             key_act;
   logic [1:0]       sync_q;
   logic             state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             rel_q;

   // normalise polarity so that 1 means pressed
   generate
      if (PRESS_LEVEL) begin : g_act_high
         assign key_act = key_raw;
      end else begin : g_act_low
         assign key_act = ~key_raw;
      end
   endgenerate

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         sync_q  <= '0;
         state_q <= 1'b0;
         cnt_q   <= '0;
         rel_q   <= 1'b0;
      end else begin
         sync_q <= {sync_q[0], key_act};
         rel_q  <= 1'b0;
         if (sync_q[1] != state_q) begin
            if (cnt_q == CNT_W'(DEBOUNCE_CYCLES - 1)) begin
               state_q <= sync_q[1];
               cnt_q   <= '0;
               rel_q   <= state_q;   // accepted 1->0 means release
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else begin
            cnt_q <= '0;
         end
      end
   end

   assign release_pulse = rel_q;
endmodule

// File: rtl/kdc_bcd_tally.sv
module kdc_bcd_tally
   import kdc_pkg::*;
(
   input  logic clk,
   input  logic arst,
   input  logic step_up,
   input  logic step_dn,
   output bcd_t tens,
   output bcd_t units
);
   bcd_t tens_q, units_q;
   logic inc, dec;

   assign inc = step_up & ~step_dn;
   assign dec = step_dn & ~step_up;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         tens_q  <= '0;
         units_q <= '0;
      end else if (inc) begin
         if (units_q == 4'd9) begin
            units_q <= '0;
            tens_q  <= (tens_q == 4'd9) ? 4'd0 : tens_q + 4'd1;
         end else begin
            units_q <= units_q + 4'd1;
         end
      end else if (dec) begin
         if (units_q == 4'd0) begin
            units_q <= 4'd9;
            tens_q  <= (tens_q == 4'd0) ? 4'd9 : tens_q - 4'd1;
         end else begin
            units_q <= units_q - 4'd1;
         end
      end
   end

   assign tens  = tens_q;
   assign units = units_q;
endmodule

// File: rtl/kdc_digit_scan.sv
module kdc_digit_scan
   import kdc_pkg::*;
#(
   parameter int SCAN_CYCLES = 50000
) (
   input  logic       clk,
   input  logic       arst,
   input  bcd_t       tens,
   input  bcd_t       units,
   output seg_t       seg,
   output logic [1:0] dig_n
);
   localparam int SCW = $clog2(SCAN_CYCLES + 1);

   logic [SCW-1:0] tick_q;
   logic           sel_q;   // 0 = units, 1 = tens

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         tick_q <= '0;
         sel_q  <= 1'b0;
      end else if (tick_q == SCW'(SCAN_CYCLES - 1)) begin
         tick_q <= '0;
         sel_q  <= ~sel_q;
      end else begin
         tick_q <= tick_q + 1'b1;
      end
   end

   assign dig_n = sel_q ? 2'b01 : 2'b10;
   assign seg   = bcd_to_seg(sel_q ? tens : units);
endmodule

// File: rtl/dual_key_decade_display.sv
module dual_key_decade_display
   import kdc_pkg::*;
#(
   parameter int CLK_HZ          = 50_000_000,
   parameter int DEBOUNCE_CYCLES = CLK_HZ / 100,
   parameter int SCAN_CYCLES     = CLK_HZ / 1000,
   parameter bit PRESS_LEVEL     = 1'b1
) (
   input  logic       clk,
   input  logic       arst,
   input  logic       key_up,
   input  logic       key_dn,
   output logic [6:0] seg,
   output logic [1:0] dig_n
);
   localparam int NKEYS = 2;

   generate
      if (DEBOUNCE_CYCLES < 2) begin : g_bad_deb
         $error("DEBOUNCE_CYCLES must be at least 2");
      end
      if (SCAN_CYCLES < 1) begin : g_bad_scan
         $error("SCAN_CYCLES must be at least 1");
      end
   endgenerate

   logic [NKEYS-1:0] key_raw;
   logic [NKEYS-1:0] steps;
   logic             up_step, dn_step;
   bcd_t             tens_q, units_q;

   assign key_raw = {key_dn, key_up};

   for (genvar k = 0; k < NKEYS; k++) begin : g_key
      kdc_key_filter #(
         .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES),
         .PRESS_LEVEL    (PRESS_LEVEL)
      ) u_flt (
         .clk          (clk),
         .arst         (arst),
         .key_raw      (key_raw[k]),
         .release_pulse(steps[k])
      );
   end

   assign up_step = steps[0];
   assign dn_step = steps[1];

   kdc_bcd_tally u_tally (
      .clk    (clk),
      .arst   (arst),
      .step_up(up_step),
      .step_dn(dn_step),
      .tens   (tens_q),
      .units  (units_q)
   );

   kdc_digit_scan #(.SCAN_CYCLES(SCAN_CYCLES)) u_scan (
      .clk  (clk),
      .arst (arst),
      .tens (tens_q),
      .units(units_q),
      .seg  (seg),
      .dig_n(dig_n)
   );
endmodule

// File: rtl/kdc_checker.sv
module kdc_checker (
   input logic       clk,
   input logic       arst,
   input logic [1:0] dig_n,
   input logic       up_step,
   input logic       dn_step,
   input logic [3:0] tens,
   input logic [3:0] units
);
   logic [6:0] val;
   always_comb val = 7'(tens) * 7'd10 + 7'(units);

   p_one_digit_r9: assert property (@(posedge clk) disable iff (arst)
      $countones(~dig_n) == 1);

   p_bcd_range_r11: assert property (@(posedge clk) disable iff (arst)
      (tens <= 4'd9) && (units <= 4'd9));

   p_up_single_r12: assert property (@(posedge clk) disable iff (arst)
      up_step |=> !up_step);

   p_dn_single_r12: assert property (@(posedge clk) disable iff (arst)
      dn_step |=> !dn_step);

   // R1 and R3
   p_inc_r1: assert property (@(posedge clk) disable iff (arst)
      (up_step && !dn_step) |=>
         (val == (($past(val) == 7'd99) ? 7'd0 : $past(val) + 7'd1)));

   // R2 and R4
   p_dec_r2: assert property (@(posedge clk) disable iff (arst)
      (dn_step && !up_step) |=>
         (val == (($past(val) == 7'd0) ? 7'd99 : $past(val) - 7'd1)));

   p_cancel_r7: assert property (@(posedge clk) disable iff (arst)
      (up_step && dn_step) |=> ($stable(tens) && $stable(units)));

   p_idle_r5: assert property (@(posedge clk) disable iff (arst)
      (!up_step && !dn_step) |=> ($stable(tens) && $stable(units)));
endmodule

bind dual_key_decade_display kdc_checker u_chk (
   .clk    (clk),
   .arst   (arst),
   .dig_n  (dig_n),
   .up_step(up_step),
   .dn_step(dn_step),
   .tens   (tens_q),
   .units  (units_q)
);

// File: tb/dual_key_decade_display_tb.sv
module dual_key_decade_display_tb;
   localparam int DEB    = 8;
   localparam int SCAN   = 4;
   localparam int HOLD   = 30;
   localparam int SETTLE = 30;

   logic       clk = 1'b0;
   logic       arst = 1'b1;
   logic       key_up = 1'b0;
   logic       key_dn = 1'b0;
   logic [6:0] seg;
   logic [1:0] dig_n;

   int errors = 0;
   int checks = 0;
   int issued = 0;
   int done_n = 0;
   bit finished = 1'b0;
   int exp_q[$];
   string tag_q[$];

   always #10 clk = ~clk;   // 50 MHz

   dual_key_decade_display #(
      .DEBOUNCE_CYCLES(DEB),
      .SCAN_CYCLES    (SCAN)
   ) u_dut (
      .clk   (clk),
      .arst  (arst),
      .key_up(key_up),
      .key_dn(key_dn),
      .seg   (seg),
      .dig_n (dig_n)
   );

   function automatic int seg_digit(input logic [6:0] s);
      case (s)
         7'h3F: return 0;
         7'h06: return 1;
         7'h5B: return 2;
         7'h4F: return 3;
         7'h66: return 4;
         7'h6D: return 5;
         7'h7D: return 6;
         7'h07: return 7;
         7'h7F: return 8;
         7'h6F: return 9;
         default: return -1;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // driver side: push an expectation and wait for the monitor to compare it
   task automatic expect_val(input int v, input string req);
      exp_q.push_back(v);
      tag_q.push_back(req);
      issued++;
      wait (done_n == issued);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // which: 0 up, 1 down, 2 both
   task automatic press(input int which);
      @(negedge clk);
      if (which != 1) key_up = 1'b1;
      if (which != 0) key_dn = 1'b1;
      idle(HOLD);
      key_up = 1'b0;
      key_dn = 1'b0;
      idle(SETTLE);
   endtask

   // monitor: decode both scanned digits, then compare with the queue head
   initial begin
      forever begin
         int u, t, v;
         string r;
         wait (exp_q.size() > 0);
         u = -2;
         t = -2;
         while (u < -1 || t < -1) begin
            @(negedge clk);
            if (dig_n == 2'b10) u = seg_digit(seg);
            else if (dig_n == 2'b01) t = seg_digit(seg);
            else begin
               check(1'b0, "R9 digit enable", int'(dig_n), 1);
               u = -1;
               t = -1;
            end
         end
         v = exp_q.pop_front();
         r = tag_q.pop_front();
         check(u >= 0 && t >= 0, "R10 segment pattern", (u < 0) ? u : t, 0);
         check(t * 10 + u == v, r, t * 10 + u, v);
         done_n++;
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         check(1'b0, "watchdog", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      idle(3);
      arst = 1'b0;
      idle(5);
      expect_val(0, "R8 reset state");

      // R9: units enabled first, then toggles every SCAN cycles
      check(dig_n == 2'b10 || dig_n == 2'b01, "R9 scan legal", int'(dig_n), 2);

      press(0); expect_val(1, "R1 up");
      press(0); expect_val(2, "R1 up");
      press(0); expect_val(3, "R1 up");
      press(1); expect_val(2, "R2 down");
      press(1); press(1); expect_val(0, "R2 down to zero");
      press(1); expect_val(99, "R4 wrap down");
      press(0); expect_val(0, "R3 wrap up");

      for (int i = 0; i < 9; i++) press(0);
      expect_val(9, "R1 up to nine");
      press(0); expect_val(10, "R1 carry");
      press(1); expect_val(9, "R2 borrow");

      // R5: held key changes nothing until release
      @(negedge clk);
      key_up = 1'b1;
      idle(4 * DEB);
      expect_val(9, "R5 hold no step");
      key_up = 1'b0;
      idle(SETTLE);
      expect_val(10, "R5 step on release");

      // R6: short glitches ignored
      @(negedge clk);
      key_up = 1'b1;
      idle(DEB / 2);
      key_up = 1'b0;
      idle(SETTLE);
      @(negedge clk);
      key_dn = 1'b1;
      idle(DEB - 3);
      key_dn = 1'b0;
      idle(SETTLE);
      expect_val(10, "R6 glitch ignored");

      // R7: simultaneous release cancels
      press(2); expect_val(10, "R7 both cancel");

      // R12 observable: one release makes exactly one step
      press(1); expect_val(9, "R12 single step");

      // R8: asynchronous reset mid-run
      press(0); press(0); expect_val(11, "R1 up");
      #3 arst = 1'b1;
      idle(3);
      arst = 1'b0;
      idle(5);
      expect_val(0, "R8 reset clears");

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule